// File: doc/BRIEF.md
# Transposed Fixed-Coefficient FIR Filter

This block is a fully parallel FIR filter in transposed direct form. Each clock it can accept one real, signed fixed-point sample, qualified by a valid strobe. A fixed number of cycles later it returns one full-precision filtered sample with its own valid strobe. The tap weights are constants, given at elaboration as a packed parameter vector. Tap k is held in bits `[k*COEF_W +: COEF_W]` as a two's-complement value.

The multiplier set is pruned at elaboration. Taps whose weights share the same absolute value read one common magnitude product. Each such tap adds or subtracts that product in its own adder stage, according to its sign. Taps with a zero weight have no product at all and only pass the partial sum along. The output is not rounded or saturated, so any narrowing is left to the logic downstream.

The reset is synchronous and active high. It always clears the valid pipeline. When `DP_CLEAR` is set, it also clears every datapath register, so the filter history is flushed.

Top module: `fir_transposed`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly 6 clock cycles, whatever the tap count or the weights. A sample presented before clock edge t appears after edge t+5.
- R2: Each valid output equals sum over k of c[k]*x[n-k]. Here x[n] is the newest accepted sample, x[n-1] is the accepted sample before it, and so on. Samples older than the filter history, or from before a clearing reset, count as zero. The result is exact at width DATA_W+COEF_W+ceil(log2(NTAPS)), signed.
- R3: Cycles with `in_valid` low do not advance the filter history. A gap of any length between two samples leaves the result unchanged.
- R4: Taps with equal weight magnitude share one product. A negative weight is applied by subtraction, so weights +a and -a produce outputs of opposite sign for the same sample.
- R5: A tap whose weight is zero contributes nothing. An impulse of value v produces v*c[k] on the k-th output after it, and exactly 0 at zero-weight positions.
- R6: During reset and for the first 6 cycles after it, `out_valid` stays low. Samples in flight when reset is applied never appear at the output.
- R7: With `DP_CLEAR` set, reset forces `out_data` to 0 and empties the history. The first outputs after reset depend only on samples taken after it.
- R8: `out_data` changes only on cycles where `out_valid` is high, and otherwise holds its last value.
- R9: A most-negative weight (-2^(COEF_W-1)) and a most-negative input combine without overflow. Every accumulated term is exact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset (control path; also datapath when `DP_CLEAR`) |
| in_valid | input | 1 | Qualifies `in_data` in this cycle |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Marks a new filtered sample on `out_data` |
| out_data | output | DATA_W+COEF_W+ceil(log2(NTAPS)) | Signed full-precision filter result |

## Verification
The hardest case to reach is a reset that lands while several accepted samples are spread across the input, product, chain and output stages. At the same moment, the transposed chain must be holding partial sums across gaps in the input. The bench drives long randomly gapped runs with extreme values mixed in. It then pulses reset in the middle of a dense stretch, so that in-flight samples must vanish and later outputs must reflect only new data. Directed impulses isolate each tap's weight, including the zero taps and the opposite-sign pairs. A long run of most-negative inputs exercises the worst-case sum.

// File: rtl/fir_tp_pkg.sv
package fir_tp_pkg;
  // total cycles from accepted input to output strobe
  localparam int unsigned FIR_LAT = 6;
  // stage index (1-based) at which the transposed chain registers
  localparam int unsigned CHAIN_STAGE = 3;

  typedef enum logic [1:0] {
    TAP_NONE = 2'd0,
    TAP_ADD  = 2'd1,
    TAP_SUB  = 2'd2
  } tap_mode_e;
endpackage

// File: rtl/fir_tp_valid_pipe.sv
module fir_tp_valid_pipe #(
  parameter int DEPTH = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] stages
);
  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[DEPTH-2:0], din};
  end

  assign stages = sr;
endmodule

// File: rtl/fir_tp_mult.sv
// Registered product of the held sample and one constant weight magnitude.
module fir_tp_mult #(
  parameter int              DATA_W = 16,
  parameter int              MAG_W  = 17,
  parameter logic [MAG_W-1:0] MAG   = '0
) (
  input  logic                            clk,
  input  logic                            clr,
  input  logic signed [DATA_W-1:0]        x,
  output logic signed [DATA_W+MAG_W-1:0]  prod
);
  localparam logic signed [MAG_W-1:0] MAG_S = MAG;

  always_ff @(posedge clk) begin
    if (clr) prod <= '0;
    else     prod <= x * MAG_S;
  end
endmodule

// File: rtl/fir_tp_tap.sv
// One transposed-form adder stage: partial sum from the next tap plus a signed term.
module fir_tp_tap
  import fir_tp_pkg::*;
#(
  parameter int        ACC_W  = 35,
  parameter int        PROD_W = 33,
  parameter tap_mode_e MODE   = TAP_ADD
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     en,
  input  logic signed [PROD_W-1:0] prod,
  input  logic signed [ACC_W-1:0]  acc_in,
  output logic signed [ACC_W-1:0]  acc_out
);
  logic signed [ACC_W-1:0] ext;
  logic signed [ACC_W-1:0] term;

  assign ext = ACC_W'(prod);

  always_comb begin
    case (MODE)
      TAP_ADD: term = ext;
      TAP_SUB: term = -ext;
      default: term = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (clr)     acc_out <= '0;
    else if (en) acc_out <= acc_in + term;
  end
endmodule

// File: rtl/fir_transposed.sv
module fir_transposed
  import fir_tp_pkg::*;
#(
  parameter int                     DATA_W   = 16,
  parameter int                     COEF_W   = 16,
  parameter int                     NTAPS    = 8,
  // tap k in bits [k*COEF_W +: COEF_W]; leftmost field is the last tap
  parameter logic [NTAPS*COEF_W-1:0] COEFS   = {16'hFFFD, 16'h0005, 16'h0000, 16'h8000,
                                                16'h8000, 16'h0000, 16'hFFFB, 16'h0003},
  parameter bit                     DP_CLEAR = 1'b1
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           in_valid,
  input  logic signed [DATA_W-1:0]                       in_data,
  output logic                                           out_valid,
  output logic signed [DATA_W+COEF_W+$clog2(NTAPS)-1:0]  out_data
);
  localparam int MAG_W      = COEF_W + 1;
  localparam int PROD_W     = DATA_W + MAG_W;
  localparam int ACC_W      = DATA_W + COEF_W + $clog2(NTAPS);
  localparam int OUT_STAGES = FIR_LAT - CHAIN_STAGE;

  // ---- elaboration-time analysis of the weight vector ----
  function automatic longint coef_of(input int k);
    logic signed [COEF_W-1:0] c;
    c = COEFS[k*COEF_W +: COEF_W];
    return longint'(c);
  endfunction

  function automatic longint mag_of(input int k);
    longint c;
    c = coef_of(k);
    return (c < 0) ? -c : c;
  endfunction

  // lowest tap index with the same magnitude owns the shared product
  function automatic int leader_of(input int k);
    for (int j = 0; j < k; j++) begin
      if (mag_of(j) == mag_of(k)) return j;
    end
    return k;
  endfunction

  function automatic tap_mode_e mode_of(input int k);
    if (coef_of(k) == 0) return TAP_NONE;
    if (coef_of(k) < 0)  return TAP_SUB;
    return TAP_ADD;
  endfunction

  // ---- control path ----
  logic [FIR_LAT-1:0] stg_v;

  fir_tp_valid_pipe #(.DEPTH(FIR_LAT)) u_vpipe (
    .clk    (clk),
    .rst    (rst),
    .din    (in_valid),
    .stages (stg_v)
  );

  assign out_valid = stg_v[FIR_LAT-1];

  logic dp_clr;
  assign dp_clr = DP_CLEAR && rst;

  // ---- stage 1: sample register ----
  logic signed [DATA_W-1:0] x_r;

  always_ff @(posedge clk) begin
    if (dp_clr)        x_r <= '0;
    else if (in_valid) x_r <= in_data;
  end

  // ---- stage 2: one multiplier per distinct non-zero magnitude ----
  logic signed [PROD_W-1:0] prod [NTAPS];

  for (genvar k = 0; k < NTAPS; k++) begin : g_mul
    localparam longint MAG  = mag_of(k);
    localparam int     LEAD = leader_of(k);
    if (MAG != 0 && LEAD == k) begin : g_own
      fir_tp_mult #(
        .DATA_W (DATA_W),
        .MAG_W  (MAG_W),
        .MAG    (MAG_W'(MAG))
      ) u_mult (
        .clk  (clk),
        .clr  (dp_clr),
        .x    (x_r),
        .prod (prod[k])
      );
    end else begin : g_none
      assign prod[k] = '0;
    end
  end

  // ---- stage 3: transposed adder chain, advancing only on accepted samples ----
  logic signed [ACC_W-1:0] acc [NTAPS+1];
  assign acc[NTAPS] = '0;

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    fir_tp_tap #(
      .ACC_W  (ACC_W),
      .PROD_W (PROD_W),
      .MODE   (mode_of(k))
    ) u_tap (
      .clk     (clk),
      .clr     (dp_clr),
      .en      (stg_v[CHAIN_STAGE-2]),
      .prod    (prod[leader_of(k)]),
      .acc_in  (acc[k+1]),
      .acc_out (acc[k])
    );
  end

  // ---- stages 4..FIR_LAT: output alignment, moving only with valid data ----
  logic signed [ACC_W-1:0] dly [OUT_STAGES];

  always_ff @(posedge clk) begin
    if (dp_clr) begin
      for (int s = 0; s < OUT_STAGES; s++) dly[s] <= '0;
    end else begin
      if (stg_v[CHAIN_STAGE-1]) dly[0] <= acc[0];
      for (int s = 1; s < OUT_STAGES; s++) begin
        if (stg_v[CHAIN_STAGE-1+s]) dly[s] <= dly[s-1];
      end
    end
  end

  assign out_data = dly[OUT_STAGES-1];
endmodule

// File: rtl/fir_transposed_chk.sv
module fir_transposed_chk #(
  parameter int OUT_W    = 35,
  parameter bit DP_CLEAR = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  // cycles since reset, saturating at the pipeline latency
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3'd6) since_rst <= since_rst + 3'd1;
  end

  p_valid_delay_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd6) |-> (out_valid == $past(in_valid, 6)));

  p_quiet_after_rst_r6: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 3'd6) |-> !out_valid);

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(out_data)) |-> out_valid);

  if (DP_CLEAR) begin : g_clr
    p_cleared_after_rst_r7: assert property (@(posedge clk) disable iff (rst)
      (since_rst != 3'd6) |-> (out_data == '0));
  end
endmodule

bind fir_transposed fir_transposed_chk #(
  .OUT_W    (DATA_W + COEF_W + $clog2(NTAPS)),
  .DP_CLEAR (DP_CLEAR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/fir_transposed_bench.sv
module fir_transposed_bench;
  localparam int DW = 16;
  localparam int OW = 35;
  localparam int NT = 8;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic signed [OW-1:0] out_data;

  always #4 clk = ~clk;  // 125 MHz

  fir_transposed u_fir_transposed (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  // weights as stated in the requirements, tap 0 first
  longint cf [NT] = '{3, -5, 0, -32768, -32768, 0, 5, -3};

  int     checks = 0;
  int     errors = 0;
  bit     done   = 0;
  longint hist [NT];
  bit     vq [6];
  longint expq [4096];
  int     wr = 0;
  int     rd = 0;
  longint exp_last = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint ref_out();
    longint y = 0;
    for (int k = 0; k < NT; k++) y += cf[k] * hist[k];
    return y;
  endfunction

  // one cycle: check outputs at the falling edge, then drive the next inputs
  task automatic cyc(input bit v, input longint d, input bit r, input string req);
    longint act;
    @(negedge clk);
    act = longint'(out_data);
    chk(out_valid == vq[5], "R1 valid timing", longint'(out_valid), longint'(vq[5]));
    if (vq[5]) begin
      chk(rd < wr && act == expq[rd], req, act, (rd < wr) ? expq[rd] : 0);
      exp_last = (rd < wr) ? expq[rd] : exp_last;
      rd++;
    end else begin
      chk(act == exp_last, "R8 hold while idle", act, exp_last);
    end
    for (int i = 5; i > 0; i--) vq[i] = vq[i-1];
    if (r) begin
      for (int i = 0; i < 6; i++) vq[i] = 1'b0;
      for (int k = 0; k < NT; k++) hist[k] = 0;
      rd = wr;
      exp_last = 0;
    end else begin
      vq[0] = v;
      if (v) begin
        for (int k = NT-1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = d;
        expq[wr] = ref_out();
        wr++;
      end
    end
    rst      = r;
    in_valid = v;
    in_data  = DW'(d);
  endtask

  function automatic longint rnd_sample();
    int sel = int'($urandom % 8);
    if (sel == 0) return -32768;
    if (sel == 1) return 32767;
    return longint'($signed(16'($urandom)));
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int k = 0; k < NT; k++) hist[k] = 0;
    for (int i = 0; i < 6; i++) vq[i] = 1'b0;

    // reset state (R6, R7)
    repeat (4) cyc(0, 0, 1, "R6 reset");
    @(negedge clk);
    chk(out_valid == 1'b0, "R6 out_valid low after reset", longint'(out_valid), 0);
    chk(out_data == '0, "R7 out_data cleared", longint'(out_data), 0);
    cyc(0, 0, 0, "R7 idle");

    // unit impulse exposes each weight, zero taps and opposite signs (R4, R5)
    cyc(1, 1, 0, "R5 impulse");
    for (int i = 0; i < NT + 2; i++) cyc(1, 0, 0, "R4 R5 impulse response");
    repeat (8) cyc(0, 0, 0, "R5 drain");

    // most-negative impulse with gaps between the trailing zeros (R9, R3)
    cyc(1, -32768, 0, "R9 extreme impulse");
    for (int i = 0; i < NT; i++) begin
      repeat (i % 4) cyc(0, 12345, 0, "R3 gap");
      cyc(1, 0, 0, "R3 R9 gapped response");
    end
    repeat (8) cyc(0, 0, 0, "R3 drain");

    // contiguous full-scale negative run: worst-case accumulation (R9)
    for (int i = 0; i < 3 * NT; i++) cyc(1, -32768, 0, "R9 full-scale run");
    for (int i = 0; i < 2 * NT; i++) cyc(1, 32767, 0, "R9 full-scale run");
    repeat (8) cyc(0, 0, 0, "R9 drain");

    // constrained random with gaps (R2, R3)
    for (int i = 0; i < 1500; i++) begin
      bit v = ($urandom % 10) < 6;
      cyc(v, rnd_sample(), 0, "R2 random");
    end

    // reset while the pipeline is full of accepted samples (R6, R7)
    for (int i = 0; i < 12; i++) cyc(1, rnd_sample(), 0, "R2 dense");
    cyc(1, 999, 1, "R6 mid-run reset");
    for (int i = 0; i < 6; i++) cyc(1, rnd_sample(), 0, "R7 post-reset history");
    for (int i = 0; i < 600; i++) begin
      bit v = ($urandom % 10) < 8;
      cyc(v, rnd_sample(), 0, "R2 random after reset");
    end
    repeat (10) cyc(0, 0, 0, "R2 final drain");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule